// File: doc/BRIEF.md
# I2C Calibration Memory Target

This block is an I2C target that presents the identification and calibration store of a plug-in acquisition module. A host sees a 16-bit byte-address space with two populated windows. The first is a read-only window at 0x8000–0x83FF that holds an identification record, a factory calibration area and reserved space. The second is a 128-byte user calibration area at 0x7000–0x707F that can be written only after a key byte has opened a write gate. Each calibration area starts with the marker byte 0xAD. It ends with a check byte at offset 0x7F, equal to the XOR of the 127 bytes before it.

A host sets the internal pointer with a write transfer: the device byte with R/W=0, then the address high byte, then the low byte. Further bytes in the same transfer are data writes. A repeated START followed by the device byte with R/W=1 then streams bytes out from the pointer. A read with no address phase continues from wherever the pointer was left. SCL and SDA are sampled with the system clock. SDA is driven only as an open-drain pull-down.

Top module: `cal_store_i2c_target`

## Requirements
- R1: During and right after reset the SDA pull-down is released, and the user area is write-locked.
- R2: A device byte whose upper seven bits equal the `DEV_ADDR` parameter (0x50 by default) is ACKed. Any other device address is NACKed, and every byte after it is NACKed until the next START.
- R3: In a write transfer, the two bytes after the device byte load the pointer, high byte first. Every data byte written then advances the pointer by one, so a later read without an address phase starts where the writes stopped.
- R4: Reads stream consecutive addresses, one byte per host ACK. The transfer ends at the host NACK, and the pointer advances by one for every byte sent.
- R5: The identification record at 0x8000+i (i = 0..255) reads as the bitwise complement of i.
- R6: The factory area reads 0xAD at 0x8100 and k at 0x8100+k for k = 1..126. It reads the XOR check at 0x817F, which is 0xD2. The reserved span 0x8180–0x83FF reads 0x00.
- R7: Every address outside 0x7000–0x707F and 0x8000–0x83FF reads 0xFF, including the reserved span 0x7080–0x70FF.
- R8: After reset the user area holds 0xAD at 0x7000, 0xAD at 0x707F (the check of an all-zero body) and 0x00 elsewhere.
- R9: While locked, data bytes aimed at the user area are ACKed but leave it unchanged.
- R10: Writing 0xD2 to 0x6FFF opens the gate. User-area writes then store their data at consecutive addresses.
- R11: Writing any value other than 0xD2 to 0x6FFF closes the gate again, and later user-area writes are discarded.
- R12: Data bytes aimed at the read-only window are ACKed and never change what it reads back, whether the gate is open or not.
- R13: A STOP returns the target to idle from any point in a transfer with SDA released. The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Enables the open-drain pull-down on SDA |

## Verification
Reads are run across region edges: 0x817E into the reserved span, and 0x707F into the unmapped span. This separates an off-by-one in the window decode from an error in the pointer increment. Writes are sent to the user area in each gate state and to the read-only window with the gate open. Each write is followed by a read-back, so that a dropped write, a misplaced write and a write that wrongly lands can each be told apart. A wrong device address, a transfer cut short by a STOP and a read with no address phase check the ACK policy, the return to idle and the pointer being carried from a write into a read.

// File: rtl/cal_store_pkg.sv
`timescale 1ns/1ps
package cal_store_pkg;

    // Window layout of the target's byte address space
    localparam logic [15:0] ROM_BASE   = 16'h8000;
    localparam logic [15:0] ROM_LAST   = 16'h83FF;
    localparam logic [15:0] FCAL_BASE  = 16'h8100;
    localparam logic [15:0] USR_BASE   = 16'h7000;
    localparam logic [15:0] GATE_ADDR  = 16'h6FFF;
    localparam int          USR_BYTES  = 128;
    localparam int          FCAL_BYTES = 128;

    localparam logic [7:0]  GATE_KEY   = 8'hD2;
    localparam logic [7:0]  AREA_MARK  = 8'hAD;
    localparam logic [7:0]  OPEN_BUS   = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RACK,
        PH_TX,
        PH_TACK
    } phase_e;

    typedef enum logic [1:0] {
        RL_DEV,
        RL_AHI,
        RL_ALO,
        RL_DATA
    } role_e;

endpackage

// File: rtl/bus_line_sampler.sv
`timescale 1ns/1ps
module bus_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_seen,
    output logic stop_seen
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl;
        logic [PIPE_W-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.scl = {pipe_q.scl[PIPE_W-2:0], scl_raw};
        pipe_d.sda = {pipe_q.sda[PIPE_W-2:0], sda_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '{scl: '1, sda: '1};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = pipe_q.scl[PIPE_W-2];
    assign scl_old = pipe_q.scl[PIPE_W-1];
    assign sda_now = pipe_q.sda[PIPE_W-2];
    assign sda_old = pipe_q.sda[PIPE_W-1];

    assign scl_rise   = scl_now & ~scl_old;
    assign scl_fall   = ~scl_now & scl_old;
    assign sda_bit    = sda_now;
    assign start_seen = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_seen  = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/cal_mem_bank.sv
`timescale 1ns/1ps
module cal_mem_bank
    import cal_store_pkg::*;
#(
    parameter int USER_BYTES = USR_BYTES,
    parameter int FCAL_SPAN  = FCAL_BYTES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    output logic        wr_open
);
    localparam int          IDX_W     = $clog2(USER_BYTES);
    localparam logic [15:0] USR_LAST  = USR_BASE + 16'(USER_BYTES - 1);
    localparam logic [15:0] FCAL_LAST = FCAL_BASE + 16'(FCAL_SPAN - 1);

    // XOR of marker and body bytes 1..FCAL_SPAN-2 of the factory area
    function automatic logic [7:0] fcal_sum();
        logic [7:0] acc;
        acc = AREA_MARK;
        for (int i = 1; i < FCAL_SPAN - 1; i++) begin
            acc = acc ^ 8'(i);
        end
        return acc;
    endfunction

    localparam logic [7:0] FCAL_CHECK = fcal_sum();

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        logic [7:0] o8;
        if (a < FCAL_BASE) begin
            o8 = 8'(a - ROM_BASE);
            return ~o8;
        end else if (a <= FCAL_LAST) begin
            o8 = 8'(a - FCAL_BASE);
            if (o8 == 8'd0) return AREA_MARK;
            if (o8 == 8'(FCAL_SPAN - 1)) return FCAL_CHECK;
            return o8;
        end
        return 8'h00;
    endfunction

    // Write gate: two-process
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (wr_en && wr_addr == GATE_ADDR) begin
            open_d = (wr_data == GATE_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign wr_open = open_q;

    // User area storage
    logic [7:0]       user_q [USER_BYTES];
    logic             wr_user;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_user = wr_en && open_q && (wr_addr >= USR_BASE) && (wr_addr <= USR_LAST);
    assign wr_idx  = IDX_W'(wr_addr - USR_BASE);
    assign rd_idx  = IDX_W'(rd_addr - USR_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // all-zero body: check byte equals the marker
            for (int i = 0; i < USER_BYTES; i++) begin
                user_q[i] <= (i == 0 || i == USER_BYTES - 1) ? AREA_MARK : 8'h00;
            end
        end else if (wr_user) begin
            user_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr >= ROM_BASE && rd_addr <= ROM_LAST) begin
            rd_data = rom_byte(rd_addr);
        end else if (rd_addr >= USR_BASE && rd_addr <= USR_LAST) begin
            rd_data = user_q[rd_idx];
        end else begin
            rd_data = OPEN_BUS;
        end
    end

endmodule

// File: rtl/cal_store_i2c_target.sv
`timescale 1ns/1ps
module cal_store_i2c_target
    import cal_store_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    typedef struct packed {
        phase_e                phase;
        role_e                 role;
        logic [CNT_W-1:0]      bits;
        logic [BYTE_BITS-1:0]  shreg;
        logic [15:0]           ptr;
        logic                  host_nack;
        logic                  wr_go;
        logic [15:0]           wr_addr;
        logic [7:0]            wr_data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic scl_rise, scl_fall, sda_bit, start_seen, stop_seen;
    logic [7:0] rd_data;
    logic wr_open;

    bus_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl_in),
        .sda_raw    (sda_in),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_bit    (sda_bit),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    cal_mem_bank mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (eng_q.ptr),
        .rd_data (rd_data),
        .wr_en   (eng_q.wr_go),
        .wr_addr (eng_q.wr_addr),
        .wr_data (eng_q.wr_data),
        .wr_open (wr_open)
    );

    always_comb begin
        eng_d       = eng_q;
        eng_d.wr_go = 1'b0;
        if (stop_seen) begin
            eng_d.phase = PH_IDLE;
        end else if (start_seen) begin
            eng_d.phase = PH_RX;
            eng_d.role  = RL_DEV;
            eng_d.bits  = '0;
        end else begin
            unique case (eng_q.phase)
                PH_RX: begin
                    if (scl_rise) begin
                        eng_d.shreg = {eng_q.shreg[BYTE_BITS-2:0], sda_bit};
                        eng_d.bits  = eng_q.bits + 1'b1;
                    end else if (scl_fall && eng_q.bits == CNT_W'(BYTE_BITS)) begin
                        eng_d.bits  = '0;
                        eng_d.phase = PH_RACK;
                        unique case (eng_q.role)
                            RL_DEV: begin
                                if (eng_q.shreg[7:1] != DEV_ADDR) eng_d.phase = PH_IDLE;
                            end
                            RL_AHI: eng_d.ptr[15:8] = eng_q.shreg;
                            RL_ALO: eng_d.ptr[7:0]  = eng_q.shreg;
                            RL_DATA: begin
                                eng_d.wr_go   = 1'b1;
                                eng_d.wr_addr = eng_q.ptr;
                                eng_d.wr_data = eng_q.shreg;
                                eng_d.ptr     = eng_q.ptr + 16'd1;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_RACK: begin
                    if (scl_fall) begin
                        eng_d.bits = '0;
                        if (eng_q.role == RL_DEV && eng_q.shreg[0]) begin
                            eng_d.shreg = rd_data;
                            eng_d.ptr   = eng_q.ptr + 16'd1;
                            eng_d.phase = PH_TX;
                        end else begin
                            eng_d.phase = PH_RX;
                            unique case (eng_q.role)
                                RL_DEV:  eng_d.role = RL_AHI;
                                RL_AHI:  eng_d.role = RL_ALO;
                                default: eng_d.role = RL_DATA;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (eng_q.bits == CNT_W'(BYTE_BITS - 1)) begin
                            eng_d.bits  = '0;
                            eng_d.phase = PH_TACK;
                        end else begin
                            eng_d.shreg = {eng_q.shreg[BYTE_BITS-2:0], 1'b1};
                            eng_d.bits  = eng_q.bits + 1'b1;
                        end
                    end
                end
                PH_TACK: begin
                    if (scl_rise) begin
                        eng_d.host_nack = sda_bit;
                    end else if (scl_fall) begin
                        if (!eng_q.host_nack) begin
                            eng_d.shreg = rd_data;
                            eng_d.ptr   = eng_q.ptr + 16'd1;
                            eng_d.phase = PH_TX;
                        end else begin
                            eng_d.phase = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: PH_IDLE, role: RL_DEV, bits: '0, shreg: '0,
                       ptr: '0, host_nack: 1'b0, wr_go: 1'b0,
                       wr_addr: '0, wr_data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_drive_low = (eng_q.phase == PH_RACK) ||
                           (eng_q.phase == PH_TX && !eng_q.shreg[BYTE_BITS-1]);

    // Observation points for the bound checker
    phase_e      mon_phase;
    logic        mon_wr_go;
    logic [15:0] mon_wr_addr;
    logic [7:0]  mon_wr_data;
    logic [15:0] mon_ptr;
    assign mon_phase   = eng_q.phase;
    assign mon_wr_go   = eng_q.wr_go;
    assign mon_wr_addr = eng_q.wr_addr;
    assign mon_wr_data = eng_q.wr_data;
    assign mon_ptr     = eng_q.ptr;

endmodule

// File: rtl/cal_store_checker.sv
`timescale 1ns/1ps
module cal_store_checker
    import cal_store_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        scl_in,
    input logic        sda_drive_low,
    input logic        stop_seen,
    input phase_e      phase,
    input logic        wr_go,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic [15:0] ptr,
    input logic        wr_open
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!sda_drive_low && !wr_open));

    assert_ptr_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (ptr == wr_addr + 16'd1));

    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && wr_addr == GATE_ADDR) |=> $stable(wr_open));

    assert_gate_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_addr == GATE_ADDR && wr_data == GATE_KEY) |=> wr_open);

    assert_gate_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_addr == GATE_ADDR && wr_data != GATE_KEY) |=> !wr_open);

    assert_stop_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (phase == PH_IDLE && !sda_drive_low));

    assert_drive_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_in);

endmodule

bind cal_store_i2c_target cal_store_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .stop_seen     (stop_seen),
    .phase         (mon_phase),
    .wr_go         (mon_wr_go),
    .wr_addr       (mon_wr_addr),
    .wr_data       (mon_wr_data),
    .ptr           (mon_ptr),
    .wr_open       (wr_open)
);

// File: tb/cal_store_i2c_target_tb.sv
`timescale 1ns/1ps
module cal_store_i2c_target_tb_top;

    localparam int         Q   = 80;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic drv;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~drv;

    cal_store_i2c_target dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_drive_low (drv)
    );

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: pops the expected item for every observed byte or ACK bit
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL scoreboard actual=%h expected=none", obs_val);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, obs_val, e.val);
            end
        end
    end

    task automatic bit_out(input logic b);
        sda_m = b;
        #Q scl_m = 1'b1;
        #(2*Q) scl_m = 1'b0;
        #Q;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #Q b = sda_line;
        #Q scl_m = 1'b0;
        #Q;
    endtask

    task automatic i2c_start();
        sda_m = 1'b0;
        #Q scl_m = 1'b0;
        #Q;
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b0;
        #Q;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b1;
        #(2*Q);
    endtask

    // Write one byte; the ACK bit seen is compared as 1 = ACK
    task automatic wb(input logic [7:0] d, input logic exp_ack, input string req);
        logic b;
        push_exp({7'b0, exp_ack}, req);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        obs_val = {7'b0, ~b};
        ->obs_ev;
    endtask

    task automatic rb(input logic last);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(last);
        obs_val = v;
        ->obs_ev;
    endtask

    task automatic set_ptr(input logic [15:0] a, input string req);
        i2c_start();
        wb({DEV, 1'b0}, 1'b1, "R2");
        wb(a[15:8], 1'b1, req);
        wb(a[7:0], 1'b1, req);
    endtask

    task automatic read_run(input bit rep, input int n, input logic [7:0] ev [4], input string req);
        if (rep) i2c_rstart();
        else     i2c_start();
        wb({DEV, 1'b1}, 1'b1, "R2");
        for (int i = 0; i < n; i++) begin
            push_exp(ev[i], req);
            rb(i == n - 1);
        end
        i2c_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        #50;
        check("R1 drive during reset", {7'b0, drv}, 8'h00);
        #50 rst_n = 1'b1;
        #200;
        check("R1 drive after reset", {7'b0, drv}, 8'h00);

        // identification record, sequential read
        set_ptr(16'h8000, "R3");
        read_run(1'b1, 4, '{8'hFF, 8'hFE, 8'hFD, 8'hFC}, "R4 R5");

        // factory area and its edge into reserved space
        set_ptr(16'h8100, "R3");
        read_run(1'b1, 1, '{8'hAD, 8'h00, 8'h00, 8'h00}, "R6");
        set_ptr(16'h817E, "R3");
        read_run(1'b1, 3, '{8'h7E, 8'hD2, 8'h00, 8'h00}, "R6 R4");

        // user area reset content and its edge into unmapped space
        set_ptr(16'h7000, "R3");
        read_run(1'b1, 3, '{8'hAD, 8'h00, 8'h00, 8'h00}, "R8");
        set_ptr(16'h707F, "R3");
        read_run(1'b1, 2, '{8'hAD, 8'hFF, 8'h00, 8'h00}, "R7 R8");
        set_ptr(16'h1234, "R3");
        read_run(1'b1, 2, '{8'hFF, 8'hFF, 8'h00, 8'h00}, "R7");

        // locked write is acked and discarded
        set_ptr(16'h7001, "R3");
        wb(8'h11, 1'b1, "R9");
        i2c_stop();
        set_ptr(16'h7001, "R3");
        read_run(1'b1, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R9");

        // foreign device address: NACK, then ignored until START
        i2c_start();
        wb({7'h51, 1'b0}, 1'b0, "R2");
        wb(8'h70, 1'b0, "R2");
        i2c_stop();
        i2c_start();
        wb({7'h51, 1'b1}, 1'b0, "R2");
        i2c_stop();

        // transfer cut by STOP after the high address byte
        i2c_start();
        wb({DEV, 1'b0}, 1'b1, "R2");
        wb(8'h70, 1'b1, "R13");
        i2c_stop();
        #Q;
        check("R13 released after stop", {7'b0, drv}, 8'h00);
        set_ptr(16'h7000, "R3");
        read_run(1'b1, 1, '{8'hAD, 8'h00, 8'h00, 8'h00}, "R13");

        // open gate, write three bytes, read back
        set_ptr(16'h6FFF, "R3");
        wb(8'hD2, 1'b1, "R10");
        i2c_stop();
        set_ptr(16'h7001, "R3");
        wb(8'h11, 1'b1, "R10");
        wb(8'h22, 1'b1, "R10");
        wb(8'h33, 1'b1, "R10");
        i2c_stop();
        read_run(1'b0, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R3 pointer after writes");
        set_ptr(16'h7001, "R3");
        read_run(1'b1, 3, '{8'h11, 8'h22, 8'h33, 8'h00}, "R10");

        // read-only window stays intact with gate open
        set_ptr(16'h8000, "R3");
        wb(8'h55, 1'b1, "R12");
        wb(8'h66, 1'b1, "R12");
        i2c_stop();
        set_ptr(16'h8000, "R3");
        read_run(1'b1, 2, '{8'hFF, 8'hFE, 8'h00, 8'h00}, "R12");

        // a different value at the gate address closes it
        set_ptr(16'h6FFF, "R3");
        wb(8'h3C, 1'b1, "R11");
        i2c_stop();
        set_ptr(16'h7002, "R3");
        wb(8'h99, 1'b1, "R11");
        i2c_stop();
        set_ptr(16'h7002, "R3");
        read_run(1'b1, 1, '{8'h22, 8'h00, 8'h00, 8'h00}, "R11");

        #1000;
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end

endmodule